// File: doc/BRIEF.md
# Single-Wire Device Selection Layer

This block decides whether a device on a shared single-wire bus is being addressed. It sits between the bit-slot layer, which turns line activity into one-bit time slots, and the memory-command layer. It holds a 64-bit identity built at elaboration: an 8-bit family code, a 48-bit serial number and an 8-bit check byte computed from those 56 bits. After each bus reset it collects one command byte from eight host-written slots and then runs that command.

Four commands are known. The first reads the identity out. The second compares it with an identity sent by the host. The third takes part in a binary-tree search among many devices. The fourth selects the device at once. When selection succeeds the block raises `selected` and stops using slots, so the memory layer takes over. A device that fails a match, drops out of a search or gets an unknown code goes quiet until the next bus reset.

For each slot the block states beforehand whether it drives the slot (`tx_en`) and with which value (`tx_bit`). The slot layer pulls the line low when `tx_en` is high and `tx_bit` is 0. After the slot it reports the sampled line level on `slot_bit` with a one-cycle `slot_go` pulse.

Top module: `rom_select`

## Requirements
- R1: After `rst_n` or a `bus_reset` pulse, `selected` and `tx_en` are low. The next eight slots form the command byte, with the first slot as bit 0.
- R2: Code 33h makes the block drive 64 slots with identity bits 0 to 63 in order. It raises `selected` after the 64th slot.
- R3: Identity bit i is sent in position i. Bits 7:0 hold the family code (default 09h) and bits 55:8 hold the serial number. Bits 63:56 hold a CRC with polynomial x^8+x^5+x^4+1 over bits 0..55, shifted LSB first from a zero start.
- R4: Code 55h makes the block read 64 host bits. `selected` rises after the 64th only if every bit equals the identity bit of the same index; otherwise the block goes quiet.
- R5: Code F0h makes the block handle each identity bit in three slots: it drives the bit, then drives its complement, then reads the host's bit.
- R6: In search, a host bit that differs from the identity bit makes the block drive nothing and never select until the next bus reset. If all 64 host bits agree, `selected` rises after the 64th host bit.
- R7: Code CCh raises `selected` in the cycle after the eighth command slot, with no identity transfer.
- R8: Any other code leaves `selected` low and `tx_en` low for every following slot until a bus reset.
- R9: While `selected` is high, slots have no effect: `tx_en` stays low and `selected` stays high until a bus reset.
- R10: A `bus_reset` ends any command in progress. The next slots are again taken as a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse when a bus reset is detected |
| slot_go | input | 1 | One-cycle pulse when a time slot has completed |
| slot_bit | input | 1 | Line level sampled in the completed slot |
| tx_en | output | 1 | Block drives the coming slot |
| tx_bit | output | 1 | Value to drive when `tx_en` is high (0 pulls low) |
| selected | output | 1 | Device is selected for memory commands |

## Verification
The assertions assume that `slot_go` and `bus_reset` are single-cycle pulses. They assume `tx_en`/`tx_bit` are read before a slot completes, and that a `bus_reset` takes priority over a `slot_go` in the same cycle. The stimulus drives every slot as a one-cycle pulse at the falling clock edge, never together with a bus reset. It samples the drive outputs one full cycle after each pulse. For driven slots it feeds back the line level that a lone device on the bus would produce.

// File: rtl/rom_sel_pkg.sv
package rom_sel_pkg;

  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CHK_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;
  localparam int ID_W   = BODY_W + CHK_W;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_SKIP   = 8'hCC;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH,
    ST_SEL,
    ST_WAIT
  } rom_state_e;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_COMP,
    PH_ECHO
  } srch_ph_e;

  // reflected form of x^8+x^5+x^4+1, data taken LSB first
  function automatic logic [CHK_W-1:0] body_crc(input logic [BODY_W-1:0] body);
    logic [CHK_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb  = acc[0] ^ body[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ 8'h8C;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rom_byte_rx.sv
module rom_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] byte_now,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign byte_now = {bit_in, sh_q[W-1:1]};
  assign done     = shift_en && (cnt_q == LAST);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d  = byte_now;
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R1
  byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (cnt_q == '0));

endmodule

// File: rtl/rom_id_src.sv
module rom_id_src
  import rom_sel_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h09,
  parameter logic [SER_W-1:0] SERIAL = 48'h1A2B3C4D5E6F
) (
  input  logic [$clog2(ID_W)-1:0] idx,
  output logic                    id_bit
);
  localparam logic [BODY_W-1:0] BODY  = {SERIAL, FAMILY};
  localparam logic [CHK_W-1:0]  CHECK = body_crc(BODY);

  logic [ID_W-1:0] id_word;

  genvar g;
  generate
    for (g = 0; g < ID_W; g++) begin : g_bits
      if (g < BODY_W) begin : g_body
        assign id_word[g] = BODY[g];
      end else begin : g_chk
        assign id_word[g] = CHECK[g - BODY_W];
      end
    end
  endgenerate

  assign id_bit = id_word[idx];

endmodule

// File: rtl/rom_walk_ctrl.sv
module rom_walk_ctrl
  import rom_sel_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_reset,
  input  logic                    slot_go,
  input  logic                    slot_bit,
  input  logic                    cmd_done,
  input  logic [7:0]              cmd_byte,
  input  logic                    id_bit,
  output logic [$clog2(ID_W)-1:0] idx,
  output logic                    rx_en,
  output logic                    tx_en,
  output logic                    tx_bit,
  output logic                    selected
);
  localparam int IW = $clog2(ID_W);
  localparam logic [IW-1:0] IDX_LAST = IW'(ID_W - 1);

  rom_state_e    st_q, st_d;
  srch_ph_e      ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          miss_q, miss_d;
  logic          last_bit;
  logic          differ;

  assign last_bit = (idx_q == IDX_LAST);
  assign differ   = (slot_bit != id_bit);
  assign idx      = idx_q;
  assign rx_en    = (st_q == ST_CMD) && slot_go && !bus_reset;
  assign selected = (st_q == ST_SEL);

  always_comb begin
    tx_en  = 1'b0;
    tx_bit = 1'b1;
    if (st_q == ST_READ) begin
      tx_en  = 1'b1;
      tx_bit = id_bit;
    end else if (st_q == ST_SRCH && ph_q != PH_ECHO) begin
      tx_en  = 1'b1;
      tx_bit = (ph_q == PH_TRUE) ? id_bit : ~id_bit;
    end
  end

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    miss_d = miss_q;
    if (bus_reset) begin
      st_d   = ST_CMD;
      ph_d   = PH_TRUE;
      idx_d  = '0;
      miss_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_CMD: begin
          if (cmd_done) begin
            idx_d  = '0;
            ph_d   = PH_TRUE;
            miss_d = 1'b0;
            unique case (cmd_byte)
              OP_READ:   st_d = ST_READ;
              OP_MATCH:  st_d = ST_MATCH;
              OP_SEARCH: st_d = ST_SRCH;
              OP_SKIP:   st_d = ST_SEL;
              default:   st_d = ST_WAIT;
            endcase
          end
        end
        ST_READ: begin
          if (slot_go) begin
            if (last_bit) st_d = ST_SEL;
            else          idx_d = idx_q + 1'b1;
          end
        end
        ST_MATCH: begin
          if (slot_go) begin
            miss_d = miss_q | differ;
            if (last_bit) st_d = (miss_q | differ) ? ST_WAIT : ST_SEL;
            else          idx_d = idx_q + 1'b1;
          end
        end
        ST_SRCH: begin
          if (slot_go) begin
            unique case (ph_q)
              PH_TRUE: ph_d = PH_COMP;
              PH_COMP: ph_d = PH_ECHO;
              default: begin
                ph_d = PH_TRUE;
                if (differ)        st_d = ST_WAIT;
                else if (last_bit) st_d = ST_SEL;
                else               idx_d = idx_q + 1'b1;
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CMD;
      ph_q   <= PH_TRUE;
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      miss_q <= miss_d;
    end
  end

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected);

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && !tx_en));

  // R5
  comp_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRCH && ph_q == PH_TRUE && slot_go && !bus_reset)
      |=> (tx_en && tx_bit != $past(tx_bit)));

  // R6
  quiet_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !bus_reset) |=> (!tx_en && !selected));

  // R7
  skip_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD && cmd_done && cmd_byte == OP_SKIP && !bus_reset) |=> selected);

endmodule

// File: rtl/rom_select.sv
module rom_select
  import rom_sel_pkg::*;
#(
  parameter logic [7:0]  FAMILY = 8'h09,
  parameter logic [47:0] SERIAL = 48'h1A2B3C4D5E6F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic slot_go,
  input  logic slot_bit,
  output logic tx_en,
  output logic tx_bit,
  output logic selected
);
  localparam int IW = $clog2(ID_W);

  logic [IW-1:0] idx;
  logic          id_bit;
  logic          rx_en;
  logic          cmd_done;
  logic [7:0]    cmd_byte;

  rom_byte_rx #(.W(8)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (bus_reset),
    .shift_en (rx_en),
    .bit_in   (slot_bit),
    .byte_now (cmd_byte),
    .done     (cmd_done)
  );

  rom_id_src #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
    .idx    (idx),
    .id_bit (id_bit)
  );

  rom_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .slot_go   (slot_go),
    .slot_bit  (slot_bit),
    .cmd_done  (cmd_done),
    .cmd_byte  (cmd_byte),
    .id_bit    (id_bit),
    .idx       (idx),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .tx_bit    (tx_bit),
    .selected  (selected)
  );

endmodule

// File: tb/rom_select_tb.sv
module rom_select_tb_top;

  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'h1A2B3C4D5E6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic slot_go = 1'b0;
  logic slot_bit = 1'b1;
  logic tx_en, tx_bit, selected;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [63:0] ident;

  always #5 clk = ~clk;

  rom_select #(.FAMILY(FAM), .SERIAL(SER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .slot_go(slot_go), .slot_bit(slot_bit),
    .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected)
  );

  // vector: {code, exp_selected, exp_tx_en, exp_tx_bit}
  localparam int NV = 7;
  localparam logic [10:0] VEC [NV] = '{
    {8'hCC, 3'b101}, {8'h33, 3'b011}, {8'h55, 3'b001}, {8'hF0, 3'b011},
    {8'h00, 3'b001}, {8'hA5, 3'b001}, {8'hFF, 3'b001}
  };

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] r;
    logic [7:0] n;
    logic       f;
    r = 8'h00;
    for (int k = 0; k < 56; k++) begin
      f    = d[k] ^ r[0];
      n[7] = f;
      n[6] = r[7];
      n[5] = r[6];
      n[4] = r[5];
      n[3] = r[4] ^ f;
      n[2] = r[3] ^ f;
      n[1] = r[2];
      n[0] = r[1];
      r = n;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic slot(input logic b);
    slot_bit = b;
    slot_go  = 1'b1;
    @(negedge clk);
    slot_go  = 1'b0;
    slot_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_slot(output logic got_en, output logic line);
    got_en = tx_en;
    line   = tx_en ? tx_bit : 1'b1;
    slot(line);
  endtask

  task automatic breset();
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) slot(b[k]);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic e, l;
    logic [63:0] rd;
    ident = {ref_crc({SER, FAM}), SER, FAM};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sel after rst_n", selected, 0);
    check("R1 tx_en after rst_n", tx_en, 0);

    // table walk: R1 R2 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      breset();
      send_byte(VEC[v][10:3]);
      check("R7/R8 table selected", selected, VEC[v][2]);
      check("R2/R5 table tx_en", tx_en, VEC[v][1]);
      if (VEC[v][1]) check("R3 table first bit", tx_bit, VEC[v][0]);
    end

    // R2 R3 full identity read
    breset();
    send_byte(8'h33);
    rd = '0;
    for (int k = 0; k < 64; k++) begin
      read_slot(e, l);
      rd[k] = l;
    end
    check("R3 identity read", rd, ident);
    check("R2 selected after read", selected, 1);

    // R9 slots ignored when selected
    for (int k = 0; k < 4; k++) slot(k[0]);
    check("R9 tx_en while selected", tx_en, 0);
    check("R9 still selected", selected, 1);

    // R4 matching identity
    breset();
    send_byte(8'h55);
    for (int k = 0; k < 63; k++) slot(ident[k]);
    check("R4 not selected before last", selected, 0);
    slot(ident[63]);
    check("R4 match selects", selected, 1);

    // R4 wrong last bit
    breset();
    send_byte(8'h55);
    for (int k = 0; k < 64; k++) slot(k == 63 ? ~ident[k] : ident[k]);
    check("R4 mismatch not selected", selected, 0);
    check("R4 mismatch no drive", tx_en, 0);

    // R5 R6 full search
    breset();
    send_byte(8'hF0);
    begin
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < 64; k++) begin
        logic a, b, ea, eb;
        read_slot(ea, a);
        read_slot(eb, b);
        if (!(ea && eb && a == ident[k] && b == ~ident[k])) ok = 1'b0;
        slot(ident[k]);
      end
      check("R5 bit then complement", ok, 1);
    end
    check("R6 search selects", selected, 1);

    // R6 drop-out at bit 10
    breset();
    send_byte(8'hF0);
    for (int k = 0; k < 11; k++) begin
      read_slot(e, l);
      read_slot(e, l);
      slot(k == 10 ? ~ident[k] : ident[k]);
    end
    for (int k = 0; k < 3; k++) begin
      check("R6 quiet after drop", tx_en, 0);
      slot(1'b0);
    end
    check("R6 not selected after drop", selected, 0);

    // R8 unknown code then a skip code is ignored
    breset();
    send_byte(8'h3C);
    send_byte(8'hCC);
    check("R8 skip ignored after unknown", selected, 0);
    check("R8 no drive after unknown", tx_en, 0);

    // R10 reset during read, then skip
    breset();
    send_byte(8'h33);
    for (int k = 0; k < 5; k++) read_slot(e, l);
    breset();
    check("R10 drive stopped", tx_en, 0);
    send_byte(8'hCC);
    check("R10 new command after reset", selected, 1);

    // R10 reset in middle of command byte
    breset();
    slot(1'b1); slot(1'b1); slot(1'b0);
    breset();
    send_byte(8'h33);
    check("R10 partial byte discarded", tx_en, 1);
    check("R10 partial byte first bit", tx_bit, ident[0]);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule